// File: doc/BRIEF.md
# Radio Receive Payload Reader

This block is a hardware SPI master that pulls one received packet out of a radio transceiver. The radio sits on a four-wire SPI link. A host pulses `start` with a pipe number and a signed byte request. The reader first samples the radio's status byte to see whether a packet is waiting and whether it came in on the requested pipe. If so, it asks the radio for the payload length. It then streams up to the requested number of payload bytes out of `dataOut`, each marked by `dataValid`. Last, it writes the status register to clear the data-ready flag.

The outcome is a signed code presented with a one-cycle `done` pulse. A positive value is the number of bytes delivered, 0 means nothing was delivered, and -1 means an error. There are two error cases: a pipe number the radio cannot have, or a corrupted length report. In the second case the radio's receive buffer is flushed before `done`. Each command is sent in its own chip-select frame, and chip select stays high for at least one SPI clock period between frames.

Top module: `rx_payload_reader`

## Requirements
- R1: A start with `pipeReq` greater than 5 (pipes are 0..5) sends no frame and raises `done` in the cycle after the start edge, with `result` = -1.
- R2: A start with a valid pipe and `countReq` of zero or less sends no frame and raises `done` in the cycle after the start edge, with `result` = 0. A request above 32 is treated as 32.
- R3: The first frame is a single filler byte 0xFF. The byte returned in that frame is the status byte. A packet counts as available only when status bit 6 is 1 and status bits 3:1 equal the requested pipe. Otherwise the transaction ends after this one frame with `result` = 0.
- R4: The length query is one frame of two bytes: command 0x60, then filler 0xFF. The byte returned during the filler is the payload length.
- R5: A reported length above 32 causes one further frame holding only the flush command 0xE2. The transaction then ends with `result` = -1, with no payload read and no status write.
- R6: Otherwise n = min(clamped request, length). The payload frame sends command 0x61 followed by n filler bytes of 0xFF. Each byte returned during a filler appears on `dataOut` with a one-cycle `dataValid` pulse, in arrival order. `dataValid` is only ever high while `busy` is high.
- R7: After the payload frame, a two-byte frame writes the status register: command 0x27, then data 0x40, which clears only the data-ready flag. The transaction then ends with `result` = n, a value in 0..32.
- R8: SPI runs in mode 0, MSB first. `sclk` is low whenever `csN` is high. `mosi` holds steady while `sclk` is high. `miso` is sampled on the rising edge. `csN` stays high for at least 2*CLK_DIV clock cycles before each frame.
- R9: `done` is a single-cycle pulse, and `csN` is high while it is asserted. `busy` is high from the cycle after an accepted start until `done`. A `start` pulse while `busy` is high is ignored and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled only while idle) |
| pipeReq | input | 3 | Requested receive pipe |
| countReq | input | RES_W | Signed maximum byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_W | Signed outcome: count, 0, or -1 |
| dataOut | output | 8 | Payload byte |
| dataValid | output | 1 | Strobe for `dataOut` |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to radio |
| miso | input | 1 | SPI data from radio |
| csN | output | 1 | SPI chip select, active low |

## Verification
Argument errors are due on the first clock edge after start. The bench checks `done` and `result` at the very next falling edge, and properties check the same relation one cycle out. Radio-driven transactions take a variable number of cycles. For these, the bench waits for the `done` pulse and then checks three things: the frames that a mode-0 radio model decoded, the bytes it counted, and the byte stream collected on `dataValid`. It confirms on the following falling edge that `done` has dropped. Chip-select gaps are counted in clock edges at each falling edge of `csN`.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;

  // byte the shifter should send next
  typedef enum logic [2:0] {
    TX_FILL,
    TX_WIDTH,
    TX_FLUSH,
    TX_READ,
    TX_WRSTAT,
    TX_CLRVAL
  } txSel_e;

  // which command frame is in flight
  typedef enum logic [2:0] {
    FR_STAT,
    FR_WIDTH,
    FR_FLUSH,
    FR_READ,
    FR_CLEAR
  } frame_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   go;
    txSel_e txSel;
    logic   latchReq;
    logic   capWidth;
    logic   decLen;
    logic   emitByte;
    logic   setZero;
    logic   setErr;
    logic   setCount;
  } dpCtl_t;

  // datapath -> control conditions
  typedef struct packed {
    logic byteDone;
    logic pipeBad;
    logic countNone;
    logic readable;
    logic widthBad;
    logic lenZero;
    logic lenLast;
  } dpFlag_t;

  localparam logic [7:0] BYTE_FILL   = 8'hFF;
  localparam logic [7:0] BYTE_WIDTH  = 8'h60;
  localparam logic [7:0] BYTE_FLUSH  = 8'hE2;
  localparam logic [7:0] BYTE_READ   = 8'h61;
  localparam logic [7:0] BYTE_WRSTAT = 8'h27;
  localparam logic [7:0] BYTE_CLRVAL = 8'h40;

endpackage

// File: rtl/rxrd_spi_shifter.sv
module rxrd_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic [7:0] txByte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rxByte,
  output logic       byteDone
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             sclkQ;
  logic             doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txSh   <= '0;
      rxSh   <= '0;
      sclkQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          txSh   <= txByte;
          divCnt <= '0;
          bitCnt <= '0;
          sclkQ  <= 1'b0;
        end
      end else if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        if (!sclkQ) begin
          // rising edge: capture the radio's bit
          sclkQ <= 1'b1;
          rxSh  <= {rxSh[6:0], miso};
        end else begin
          // falling edge: advance to the next bit or finish
          sclkQ <= 1'b0;
          if (bitCnt == 3'd7) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
            txSh   <= {txSh[6:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sclk     = sclkQ;
  assign mosi     = txSh[7];
  assign rxByte   = rxSh;
  assign byteDone = doneQ;

endmodule

// File: rtl/rxrd_datapath.sv
module rxrd_datapath
  import rxrd_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int NUM_PIPES = 6,
  parameter int MAX_LEN   = 32,
  parameter int RES_W     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  output dpFlag_t                 flag,
  input  logic [2:0]              pipeReq,
  input  logic signed [RES_W-1:0] countReq,
  input  logic                    miso,
  output logic                    sclk,
  output logic                    mosi,
  output logic signed [RES_W-1:0] result,
  output logic [7:0]              dataOut,
  output logic                    dataValid
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic [7:0]       txByte;
  logic [7:0]       rxByte;
  logic             byteDone;
  logic [2:0]       pipeQ;
  logic [LEN_W-1:0] countQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] totQ;
  logic [LEN_W-1:0] reqClamp;
  logic [LEN_W-1:0] widthPick;

  always_comb begin
    unique case (ctl.txSel)
      TX_WIDTH:  txByte = BYTE_WIDTH;
      TX_FLUSH:  txByte = BYTE_FLUSH;
      TX_READ:   txByte = BYTE_READ;
      TX_WRSTAT: txByte = BYTE_WRSTAT;
      TX_CLRVAL: txByte = BYTE_CLRVAL;
      default:   txByte = BYTE_FILL;
    endcase
  end

  rxrd_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctl.go),
    .txByte   (txByte),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .rxByte   (rxByte),
    .byteDone (byteDone)
  );

  // request clamp and length choice
  assign reqClamp  = (int'(countReq) > MAX_LEN) ? LEN_W'(MAX_LEN) : countReq[LEN_W-1:0];
  assign widthPick = (int'(rxByte) < int'(countQ)) ? rxByte[LEN_W-1:0] : countQ;

  always_comb begin
    flag.byteDone  = byteDone;
    flag.pipeBad   = int'(pipeReq) >= NUM_PIPES;
    flag.countNone = countReq[RES_W-1] || (countReq == '0);
    flag.readable  = rxByte[6] && (rxByte[3:1] == pipeQ);
    flag.widthBad  = int'(rxByte) > MAX_LEN;
    flag.lenZero   = (lenQ == '0);
    flag.lenLast   = (lenQ == LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ     <= '0;
      countQ    <= '0;
      lenQ      <= '0;
      totQ      <= '0;
      result    <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (ctl.latchReq) begin
        pipeQ  <= pipeReq;
        countQ <= reqClamp;
      end
      if (ctl.capWidth) begin
        lenQ <= widthPick;
        totQ <= widthPick;
      end else if (ctl.decLen) begin
        lenQ <= lenQ - LEN_W'(1);
      end
      if (ctl.emitByte) begin
        dataOut   <= rxByte;
        dataValid <= 1'b1;
      end
      if (ctl.setZero)       result <= '0;
      else if (ctl.setErr)   result <= '1;
      else if (ctl.setCount) result <= RES_W'(totQ);
    end
  end

endmodule

// File: rtl/rxrd_ctrl.sv
module rxrd_ctrl
  import rxrd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpFlag_t flag,
  output dpCtl_t  ctl,
  output logic    csN,
  output logic    busy,
  output logic    done
);

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SEND, S_WAIT, S_DONE} state_e;

  state_e           stateQ, stateD;
  frame_e           frameQ, frameD;
  logic             idxQ, idxD;
  logic [GAP_W-1:0] gapQ, gapD;
  txSel_e           txSelC;

  // byte to drive for the current frame position
  always_comb begin
    txSelC = TX_FILL;
    if (!idxQ) begin
      unique case (frameQ)
        FR_WIDTH: txSelC = TX_WIDTH;
        FR_FLUSH: txSelC = TX_FLUSH;
        FR_READ:  txSelC = TX_READ;
        FR_CLEAR: txSelC = TX_WRSTAT;
        default:  txSelC = TX_FILL;
      endcase
    end else if (frameQ == FR_CLEAR) begin
      txSelC = TX_CLRVAL;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.txSel = txSelC;
    stateD    = stateQ;
    frameD    = frameQ;
    idxD      = idxQ;
    gapD      = gapQ;

    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.latchReq = 1'b1;
          if (flag.pipeBad) begin
            ctl.setErr = 1'b1;
            stateD     = S_DONE;
          end else if (flag.countNone) begin
            ctl.setZero = 1'b1;
            stateD      = S_DONE;
          end else begin
            frameD = FR_STAT;
            idxD   = 1'b0;
            gapD   = '0;
            stateD = S_GAP;
          end
        end
      end

      S_GAP: begin
        if (gapQ == GAP_W'(GAP_CYC - 1)) stateD = S_SEND;
        else gapD = gapQ + 1'b1;
      end

      S_SEND: begin
        ctl.go = 1'b1;
        stateD = S_WAIT;
      end

      S_WAIT: begin
        if (flag.byteDone) begin
          unique case (frameQ)
            FR_STAT: begin
              if (flag.readable) begin
                frameD = FR_WIDTH;
                idxD   = 1'b0;
                gapD   = '0;
                stateD = S_GAP;
              end else begin
                ctl.setZero = 1'b1;
                stateD      = S_DONE;
              end
            end
            FR_WIDTH: begin
              if (!idxQ) begin
                idxD   = 1'b1;
                stateD = S_SEND;
              end else begin
                if (flag.widthBad) begin
                  frameD = FR_FLUSH;
                end else begin
                  ctl.capWidth = 1'b1;
                  frameD       = FR_READ;
                end
                idxD   = 1'b0;
                gapD   = '0;
                stateD = S_GAP;
              end
            end
            FR_FLUSH: begin
              ctl.setErr = 1'b1;
              stateD     = S_DONE;
            end
            FR_READ: begin
              if (!idxQ) begin
                if (flag.lenZero) begin
                  frameD = FR_CLEAR;
                  gapD   = '0;
                  stateD = S_GAP;
                end else begin
                  idxD   = 1'b1;
                  stateD = S_SEND;
                end
              end else begin
                ctl.emitByte = 1'b1;
                ctl.decLen   = 1'b1;
                if (flag.lenLast) begin
                  frameD = FR_CLEAR;
                  idxD   = 1'b0;
                  gapD   = '0;
                  stateD = S_GAP;
                end else begin
                  stateD = S_SEND;
                end
              end
            end
            default: begin
              if (!idxQ) begin
                idxD   = 1'b1;
                stateD = S_SEND;
              end else begin
                ctl.setCount = 1'b1;
                stateD       = S_DONE;
              end
            end
          endcase
        end
      end

      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      frameQ <= FR_STAT;
      idxQ   <= 1'b0;
      gapQ   <= '0;
    end else begin
      stateQ <= stateD;
      frameQ <= frameD;
      idxQ   <= idxD;
      gapQ   <= gapD;
    end
  end

  assign csN  = !((stateQ == S_SEND) || (stateQ == S_WAIT));
  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_DONE);

endmodule

// File: rtl/rx_payload_reader.sv
module rx_payload_reader
  import rxrd_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int NUM_PIPES = 6,
  parameter int MAX_LEN   = 32,
  parameter int RES_W     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [2:0]              pipeReq,
  input  logic signed [RES_W-1:0] countReq,
  output logic                    busy,
  output logic                    done,
  output logic signed [RES_W-1:0] result,
  output logic [7:0]              dataOut,
  output logic                    dataValid,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso,
  output logic                    csN
);

  dpCtl_t  ctl;
  dpFlag_t flag;

  rxrd_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flag  (flag),
    .ctl   (ctl),
    .csN   (csN),
    .busy  (busy),
    .done  (done)
  );

  rxrd_datapath #(
    .CLK_DIV   (CLK_DIV),
    .NUM_PIPES (NUM_PIPES),
    .MAX_LEN   (MAX_LEN),
    .RES_W     (RES_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .flag      (flag),
    .pipeReq   (pipeReq),
    .countReq  (countReq),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .result    (result),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

endmodule

// File: rtl/rxrd_checker.sv
module rxrd_checker #(
  parameter int NUM_PIPES = 6,
  parameter int MAX_LEN   = 32,
  parameter int RES_W     = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [2:0]              pipeReq,
  input logic signed [RES_W-1:0] countReq,
  input logic                    busy,
  input logic                    done,
  input logic signed [RES_W-1:0] result,
  input logic                    dataValid,
  input logic                    sclk,
  input logic                    mosi,
  input logic                    csN
);

  AST_BAD_PIPE_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && int'(pipeReq) >= NUM_PIPES) |=> (done && result == -1)); // R1

  AST_NO_COUNT_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && int'(pipeReq) < NUM_PIPES && countReq <= 0) |=> (done && result == 0)); // R2

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> busy); // R6

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result >= -1 && int'(result) <= MAX_LEN)); // R7

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R8

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN); // R9

endmodule

bind rx_payload_reader rxrd_checker #(
  .NUM_PIPES (NUM_PIPES),
  .MAX_LEN   (MAX_LEN),
  .RES_W     (RES_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .pipeReq   (pipeReq),
  .countReq  (countReq),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .dataValid (dataValid),
  .sclk      (sclk),
  .mosi      (mosi),
  .csN       (csN)
);

// File: tb/rx_payload_reader_tb.sv
module rx_payload_reader_tb;

  localparam int CLK_DIV = 2;
  localparam int RES_W   = 8;
  localparam int NV      = 13;

  // pipe, request, radio status, radio length, result, frames, flushes, clears
  localparam int vPipe  [NV] = '{2, 0, 5, 1, 3, 4, 6, 7, 1, 1, 1, 3, 0};
  localparam int vCount [NV] = '{5, 10, 40, 3, 3, 8, 4, 4, 0, -3, 4, 100, 1};
  localparam int vStat  [NV] = '{'h44, 'h40, 'h4A, 'h44, 'h06, 'h48, 'h4C, 'h4E, 'h42, 'h42, 'h42, 'h46, 'h71};
  localparam int vWidth [NV] = '{8, 4, 32, 8, 8, 33, 8, 8, 8, 8, 0, 20, 255};
  localparam int vRes   [NV] = '{5, 4, 32, 0, 0, -1, -1, -1, 0, 0, 0, 20, -1};
  localparam int vFrm   [NV] = '{4, 4, 4, 1, 1, 3, 0, 0, 0, 0, 4, 4, 3};
  localparam int vFlush [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1};
  localparam int vClr   [NV] = '{1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    start = 1'b0;
  logic [2:0]              pipeReq = '0;
  logic signed [RES_W-1:0] countReq = '0;
  logic                    busy, done, dataValid, sclk, mosi, csN;
  logic                    miso = 1'b0;
  logic signed [RES_W-1:0] result;
  logic [7:0]              dataOut;

  int errCnt = 0;
  int chkCnt = 0;
  int cycles = 0;

  // radio model state
  logic [7:0] mStatus = 8'h00;
  logic [7:0] mWidth  = 8'h00;
  logic [7:0] mBase   = 8'h00;
  logic [7:0] inSh    = 8'h00;
  logic [7:0] outSh   = 8'h00;
  logic [7:0] curCmd  = 8'h00;
  logic [7:0] clrVal  = 8'h00;
  int bitCnt = 0, byteInFrame = 0, frames = 0, flushes = 0, clears = 0;
  int fillerBad = 0, gapBad = 0, hiCnt = 100;
  int outIdx = 0, byteErr = 0;

  always #10 clk = ~clk;

  rx_payload_reader #(.CLK_DIV(CLK_DIV), .RES_W(RES_W)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .pipeReq   (pipeReq),
    .countReq  (countReq),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .sclk      (sclk),
    .mosi      (mosi),
    .miso      (miso),
    .csN       (csN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // chip-select high time, in clock edges (R8)
  always @(posedge clk) begin
    if (csN) hiCnt++;
    else hiCnt = 0;
  end

  always @(negedge csN) begin
    if (frames > 0 && hiCnt < 2 * CLK_DIV) gapBad++;
    frames++;
    byteInFrame = 0;
    bitCnt = 0;
    outSh = mStatus;
    miso = outSh[7];
  end

  always @(posedge sclk) begin
    if (!csN) begin
      inSh = {inSh[6:0], mosi};
      bitCnt++;
    end
  end

  always @(negedge sclk) begin
    if (!csN) begin
      if (bitCnt == 8) begin
        if (byteInFrame == 0) begin
          curCmd = inSh;
          if (inSh == 8'hE2) flushes++;
        end else if (curCmd == 8'h27) begin
          clrVal = inSh;
          clears++;
          mStatus = mStatus & ~(inSh & 8'h70);
        end else if (inSh != 8'hFF) begin
          fillerBad++;
        end
        if (curCmd == 8'h60) outSh = mWidth;
        else if (curCmd == 8'h61) outSh = mBase + 8'(byteInFrame);
        else outSh = 8'h00;
        byteInFrame++;
        bitCnt = 0;
      end else begin
        outSh = {outSh[6:0], 1'b0};
      end
      miso = outSh[7];
    end
  end

  // payload stream monitor (R6)
  always @(negedge clk) begin
    if (dataValid) begin
      if (dataOut != mBase + 8'(outIdx)) byteErr++;
      outIdx++;
    end
  end

  task automatic runVec(input int i, input bit pokeBusy);
    int resAct;
    mStatus = 8'(vStat[i]);
    mWidth  = 8'(vWidth[i]);
    mBase   = 8'(8'h10 + 8'(i * 16));
    frames = 0; flushes = 0; clears = 0; fillerBad = 0; gapBad = 0;
    outIdx = 0; byteErr = 0; clrVal = 8'h00;
    @(negedge clk);
    pipeReq  = 3'(vPipe[i]);
    countReq = RES_W'(vCount[i]);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (vFrm[i] == 0) begin
      // R1 / R2: answer due one cycle after the start edge
      check(done == 1'b1, "R1/R2 done latency", int'(done), 1);
    end else begin
      check(busy == 1'b1 && done == 1'b0, "R9 busy after start", int'(busy), 1);
    end
    for (int k = 0; k < 20000 && !done; k++) begin
      @(negedge clk);
      if (pokeBusy && k == 30) begin
        pipeReq = 3'd7;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    resAct = int'(result);
    if (vRes[i] < 0) check(resAct == vRes[i], "R1/R5 error code", resAct, vRes[i]);
    else if (vFrm[i] == 0) check(resAct == vRes[i], "R2 zero code", resAct, vRes[i]);
    else if (vClr[i] == 0) check(resAct == vRes[i], "R3 not readable", resAct, vRes[i]);
    else check(resAct == vRes[i], "R7 count result", resAct, vRes[i]);
    check(frames == vFrm[i], "R3/R4 frame count", frames, vFrm[i]);
    check(flushes == vFlush[i], "R5 flush frames", flushes, vFlush[i]);
    check(clears == vClr[i], "R7 status writes", clears, vClr[i]);
    check(outIdx == (vRes[i] > 0 ? vRes[i] : 0), "R6 bytes delivered", outIdx, vRes[i]);
    check(byteErr == 0, "R6 byte order", byteErr, 0);
    check(fillerBad == 0, "R6 filler bytes", fillerBad, 0);
    check(gapBad == 0, "R8 chip-select gap", gapBad, 0);
    if (vClr[i] != 0) begin
      check(clrVal == 8'h40, "R7 clear value", int'(clrVal), 'h40);
      check(mStatus[6] == 1'b0, "R7 flag cleared", int'(mStatus[6]), 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done pulse", int'(done), 0);
    check(int'(result) == vRes[i], "R9 result held", int'(result), vRes[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(csN == 1'b1 && sclk == 1'b0, "R8 reset idle bus", int'(csN), 1);
    check(busy == 1'b0 && done == 1'b0 && dataValid == 1'b0, "R9 reset idle", int'(busy), 0);
    check(result == 0, "R9 reset result", int'(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) runVec(i, 1'b0);
    // start pulse during a transaction must be ignored (R9)
    runVec(0, 1'b1);
    // back-to-back readable packets, chip-select gap between frames (R8)
    runVec(11, 1'b0);
    runVec(1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule